// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the per-transfer datapath of a single DMA channel. Software-side setup is represented by a one-cycle load strobe. The strobe captures a 16-bit start address, a 16-bit count, an 8-bit page, an 8-bit high page, a boundary-crossing enable and an auto-initialize flag. After the load, each pulse on `step_i` marks one completed transfer. On each such pulse the engine advances the address and decrements the count.

The engine forms a 32-bit physical bus address from the high page, the page and the address counter. How it does this depends on the `CHAN_KIND` parameter. A byte channel places the counter at bits 15:0. A word channel shifts the counter up one bit, forces bit 0 low and drops page bit 0. Without the crossing enable, the counter wraps inside its page. With the crossing enable, the counter's carry ripples into the page and then into the high page.

A terminal-count pulse marks the final transfer. At that point the channel either stops or reloads itself from its base values. A residue output reports how many units remain. The residue is in bytes, so a word channel reports twice the unit count.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the channel is inactive, `bus_addr_o` is 0, `residue_o` is 0 and `tc_o` is low.
- R2: On a byte channel, `bus_addr_o` = {high page[7:0], page[7:0], address counter[15:0]}.
- R3: On a word channel, `bus_addr_o` = {high page[7:0], page[7:1], address counter[15:0], 1'b0}. Page bit 0 never reaches the bus address.
- R4: The high page loaded with the setup values appears on `bus_addr_o[31:24]` on both channel kinds.
- R5: With the crossing enable clear, a step from address counter 0xFFFF wraps the counter to 0x0000, and the page and high page stay unchanged.
- R6: With the crossing enable set, a step from address counter 0xFFFF increments the page. On a word channel only page bits 7:1 increment. A carry out of the page increments the high page.
- R7: A loaded count N gives N+1 accepted steps. `tc_o` is high, combinationally, only during the step taken while the count is 0x0000, and only for that one cycle.
- R8: `residue_o` equals (count + 1) mod 65536 on a byte channel, and twice that on a word channel. It reads 0 after a non-repeating transfer completes.
- R9: Without auto-initialize, the channel goes inactive at terminal count. Steps then change neither `bus_addr_o` nor `residue_o` until the next load.
- R10: With auto-initialize, terminal count restores the address counter, count, page and high page from their loaded base values in the same cycle, and the channel stays active.
- R11: A load in the same cycle as a step takes precedence. The step is dropped and no terminal count is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | One-cycle setup strobe |
| base_addr_i | input | 16 | Start value of the address counter |
| base_cnt_i | input | 16 | Transfer count minus one |
| page_i | input | 8 | Page value |
| hipage_i | input | 8 | High page value (bus address bits 31:24) |
| cross_en_i | input | 1 | Allow the address carry to ripple into the page registers |
| autoinit_i | input | 1 | Reload from base values at terminal count |
| step_i | input | 1 | One pulse per completed transfer |
| bus_addr_o | output | 32 | Physical bus address |
| tc_o | output | 1 | Terminal-count pulse, high with the final step |
| residue_o | output | 17 | Remaining transfer length in bytes |
| active_o | output | 1 | Channel is accepting steps |

## Verification
The properties assume that `load_i` and `step_i` are clean one-cycle-per-event signals sampled on the rising edge. They also assume that the setup fields are stable whenever `load_i` is high. The bench drives all inputs on the falling edge, so every field is settled one half period before the sampling edge. A single stimulus stream feeds a byte instance and a word instance side by side. The stream includes steps while idle, a load that coincides with a step, and reloads in auto-initialize mode, so each property sees its trigger both inside and outside the active window.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef enum logic {
    CH_BYTE = 1'b0,
    CH_WORD = 1'b1
  } chan_kind_e;
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr
  import dma_eng_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         PAGE_W   = 8,
  parameter int         HIPAGE_W = 8,
  parameter chan_kind_e KIND     = CH_BYTE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [ADDR_W-1:0]   base_addr_i,
  input  logic [PAGE_W-1:0]   page_i,
  input  logic [HIPAGE_W-1:0] hipage_i,
  input  logic                xen_i,
  input  logic                adv_i,
  input  logic                reload_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [PAGE_W-1:0]   page_o,
  output logic [HIPAGE_W-1:0] hipage_o
);
  logic [ADDR_W-1:0]   ad_q, ad_d, bad_q;
  logic [PAGE_W-1:0]   pg_q, pg_d, bpg_q, page_plus;
  logic [HIPAGE_W-1:0] hp_q, hp_d, bhp_q;
  logic                addr_wrap, page_wrap, cur_en;

  // page carry arithmetic depends on channel kind
  generate
    if (KIND == CH_WORD) begin : g_word
      assign page_plus = {pg_q[PAGE_W-1:1] + (PAGE_W-1)'(1), pg_q[0]};
      assign page_wrap = &pg_q[PAGE_W-1:1];
    end else begin : g_byte
      assign page_plus = pg_q + PAGE_W'(1);
      assign page_wrap = &pg_q;
    end
  endgenerate

  assign addr_wrap = &ad_q;
  assign cur_en    = load_i | reload_i | adv_i;

  always_comb begin
    ad_d = ad_q;
    pg_d = pg_q;
    hp_d = hp_q;
    if (load_i) begin
      ad_d = base_addr_i;
      pg_d = page_i;
      hp_d = hipage_i;
    end else if (reload_i) begin
      ad_d = bad_q;
      pg_d = bpg_q;
      hp_d = bhp_q;
    end else if (adv_i) begin
      ad_d = ad_q + ADDR_W'(1);
      if (addr_wrap && xen_i) begin
        pg_d = page_plus;
        if (page_wrap) hp_d = hp_q + HIPAGE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad_q <= '0;
      pg_q <= '0;
      hp_q <= '0;
    end else if (cur_en) begin
      ad_q <= ad_d;
      pg_q <= pg_d;
      hp_q <= hp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_q <= '0;
      bpg_q <= '0;
      bhp_q <= '0;
    end else if (load_i) begin
      bad_q <= base_addr_i;
      bpg_q <= page_i;
      bhp_q <= hipage_i;
    end
  end

  assign addr_o   = ad_q;
  assign page_o   = pg_q;
  assign hipage_o = hp_q;
endmodule

// File: rtl/dma_cnt_ctl.sv
module dma_cnt_ctl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] base_cnt_i,
  input  logic             cross_en_i,
  input  logic             autoinit_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o,
  output logic             auto_o,
  output logic             xen_o,
  output logic             adv_o,
  output logic             reload_o,
  output logic             tc_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, bcnt_q;
  logic             act_q, act_d, auto_q, xen_q;
  logic             cnt_zero, cnt_en;

  assign cnt_zero = (cnt_q == '0);
  assign adv_o    = step_i & act_q & ~load_i;
  assign tc_o     = adv_o & cnt_zero;
  assign reload_o = tc_o & auto_q;
  assign cnt_en   = load_i | adv_o;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (load_i) begin
      cnt_d = base_cnt_i;
      act_d = 1'b1;
    end else if (adv_o) begin
      if (tc_o && auto_q) begin
        cnt_d = bcnt_q;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
        if (tc_o) act_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      act_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      auto_q <= 1'b0;
      xen_q  <= 1'b0;
    end else if (load_i) begin
      bcnt_q <= base_cnt_i;
      auto_q <= autoinit_i;
      xen_q  <= cross_en_i;
    end
  end

  assign cnt_o    = cnt_q;
  assign active_o = act_q;
  assign auto_o   = auto_q;
  assign xen_o    = xen_q;
endmodule

// File: rtl/dma_bus_map.sv
module dma_bus_map
  import dma_eng_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter int         PAGE_W   = 8,
  parameter int         HIPAGE_W = 8,
  parameter int         CNT_W    = 16,
  parameter chan_kind_e KIND     = CH_BYTE,
  localparam int        BUS_W    = HIPAGE_W + PAGE_W + ADDR_W,
  localparam int        RES_W    = CNT_W + 1
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [PAGE_W-1:0]   page_i,
  input  logic [HIPAGE_W-1:0] hipage_i,
  input  logic [CNT_W-1:0]    cnt_i,
  output logic [BUS_W-1:0]    bus_addr_o,
  output logic [RES_W-1:0]    residue_o
);
  logic [CNT_W-1:0] units;

  assign units = cnt_i + CNT_W'(1);

  generate
    if (KIND == CH_WORD) begin : g_word
      assign bus_addr_o = {hipage_i, page_i[PAGE_W-1:1], addr_i, 1'b0};
      assign residue_o  = {units, 1'b0};
    end else begin : g_byte
      assign bus_addr_o = {hipage_i, page_i, addr_i};
      assign residue_o  = {1'b0, units};
    end
  endgenerate
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_eng_pkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter int         CNT_W     = 16,
  parameter int         PAGE_W    = 8,
  parameter int         HIPAGE_W  = 8,
  parameter chan_kind_e CHAN_KIND = CH_BYTE,
  localparam int        BUS_W     = HIPAGE_W + PAGE_W + ADDR_W,
  localparam int        RES_W     = CNT_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [ADDR_W-1:0]   base_addr_i,
  input  logic [CNT_W-1:0]    base_cnt_i,
  input  logic [PAGE_W-1:0]   page_i,
  input  logic [HIPAGE_W-1:0] hipage_i,
  input  logic                cross_en_i,
  input  logic                autoinit_i,
  input  logic                step_i,
  output logic [BUS_W-1:0]    bus_addr_o,
  output logic                tc_o,
  output logic [RES_W-1:0]    residue_o,
  output logic                active_o
);
  logic [1:0]          rs_q;
  logic                rst_sync_n;
  logic [CNT_W-1:0]    cnt_w;
  logic [ADDR_W-1:0]   addr_w;
  logic [PAGE_W-1:0]   page_w;
  logic [HIPAGE_W-1:0] hipage_w;
  logic                auto_q, xen_q, adv_w, reload_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  dma_cnt_ctl #(.CNT_W(CNT_W)) cnt_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (load_i),
    .base_cnt_i (base_cnt_i),
    .cross_en_i (cross_en_i),
    .autoinit_i (autoinit_i),
    .step_i     (step_i),
    .cnt_o      (cnt_w),
    .active_o   (active_o),
    .auto_o     (auto_q),
    .xen_o      (xen_q),
    .adv_o      (adv_w),
    .reload_o   (reload_w),
    .tc_o       (tc_o)
  );

  dma_addr_ctr #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .HIPAGE_W(HIPAGE_W), .KIND(CHAN_KIND)
  ) addr_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .load_i      (load_i),
    .base_addr_i (base_addr_i),
    .page_i      (page_i),
    .hipage_i    (hipage_i),
    .xen_i       (xen_q),
    .adv_i       (adv_w),
    .reload_i    (reload_w),
    .addr_o      (addr_w),
    .page_o      (page_w),
    .hipage_o    (hipage_w)
  );

  dma_bus_map #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .HIPAGE_W(HIPAGE_W), .CNT_W(CNT_W),
    .KIND(CHAN_KIND)
  ) map_i (
    .addr_i     (addr_w),
    .page_i     (page_w),
    .hipage_i   (hipage_w),
    .cnt_i      (cnt_w),
    .bus_addr_o (bus_addr_o),
    .residue_o  (residue_o)
  );
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk
  import dma_eng_pkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter int         CNT_W     = 16,
  parameter int         PAGE_W    = 8,
  parameter int         HIPAGE_W  = 8,
  parameter chan_kind_e CHAN_KIND = CH_BYTE,
  localparam int        BUS_W     = HIPAGE_W + PAGE_W + ADDR_W,
  localparam int        RES_W     = CNT_W + 1,
  localparam int        HI_LSB    = (CHAN_KIND == CH_WORD) ? ADDR_W + 1 : ADDR_W
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             load_i,
  input logic             step_i,
  input logic             tc_o,
  input logic             active_o,
  input logic             auto_q,
  input logic             xen_q,
  input logic [BUS_W-1:0] bus_addr_o,
  input logic [RES_W-1:0] residue_o
);
  logic [CNT_W-1:0] res_units;
  generate
    if (CHAN_KIND == CH_WORD) begin : g_word
      assign res_units = residue_o[RES_W-1:1];
    end else begin : g_byte
      assign res_units = residue_o[CNT_W-1:0];
    end
  endgenerate

  // R7
  tc_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tc_o |-> (step_i && active_o && !load_i));

  // R9
  stop_after_tc_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tc_o && !auto_q) |=> !active_o);

  // R10
  auto_stays_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tc_o && auto_q) |=> active_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!active_o && !load_i) |=> ($stable(bus_addr_o) && $stable(residue_o)));

  // R8
  residue_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_i && active_o && !load_i && !tc_o) |=> (res_units == $past(res_units) - CNT_W'(1)));

  // R5
  no_cross_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_i && active_o && !load_i && !xen_q && !tc_o) |=> $stable(bus_addr_o[BUS_W-1:HI_LSB]));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W), .HIPAGE_W(HIPAGE_W),
  .CHAN_KIND(CHAN_KIND)
) chk_i (.*);

// File: tb/dma_xfer_engine_tb.sv
module dma_xfer_engine_tb_top;
  import dma_eng_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0, step_i = 1'b0, cross_en_i = 1'b0, autoinit_i = 1'b0;
  logic [15:0] base_addr_i = '0, base_cnt_i = '0;
  logic [7:0]  page_i = '0, hipage_i = '0;
  logic [31:0] bus_b, bus_w;
  logic [16:0] res_b, res_w;
  logic        tc_b, tc_w, act_b, act_w;

  always #5 clk = ~clk;

  dma_xfer_engine #(.CHAN_KIND(CH_BYTE)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .base_addr_i(base_addr_i),
    .base_cnt_i(base_cnt_i), .page_i(page_i), .hipage_i(hipage_i),
    .cross_en_i(cross_en_i), .autoinit_i(autoinit_i), .step_i(step_i),
    .bus_addr_o(bus_b), .tc_o(tc_b), .residue_o(res_b), .active_o(act_b));

  dma_xfer_engine #(.CHAN_KIND(CH_WORD)) dut_w_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .base_addr_i(base_addr_i),
    .base_cnt_i(base_cnt_i), .page_i(page_i), .hipage_i(hipage_i),
    .cross_en_i(cross_en_i), .autoinit_i(autoinit_i), .step_i(step_i),
    .bus_addr_o(bus_w), .tc_o(tc_w), .residue_o(res_w), .active_o(act_w));

  typedef struct packed {
    logic        tc;
    logic        act;
    logic [31:0] ab;
    logic [31:0] aw;
    logic [16:0] rb;
    logic [16:0] rw;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    tests = 0, fails = 0;
  bit    done = 1'b0;

  // reference model state
  logic [15:0] m_addr, m_cnt, b_addr, b_cnt;
  logic [7:0]  mb_pg, mb_hi, mw_pg, mw_hi, b_pg, b_hi;
  logic        m_act, m_auto, m_xen;

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic cyc(input string tag, input bit ld, input bit st);
    exp_t e;
    logic [8:0] ps;
    @(negedge clk);
    load_i = ld;
    step_i = st;
    e.tc = st && m_act && !ld && (m_cnt == 16'h0000);
    if (ld) begin
      m_addr = base_addr_i; m_cnt = base_cnt_i;
      mb_pg = page_i; mw_pg = page_i; mb_hi = hipage_i; mw_hi = hipage_i;
      b_addr = base_addr_i; b_cnt = base_cnt_i; b_pg = page_i; b_hi = hipage_i;
      m_xen = cross_en_i; m_auto = autoinit_i; m_act = 1'b1;
    end else if (st && m_act) begin
      if (e.tc && m_auto) begin
        m_addr = b_addr; m_cnt = b_cnt;
        mb_pg = b_pg; mw_pg = b_pg; mb_hi = b_hi; mw_hi = b_hi;
      end else begin
        if (m_addr == 16'hFFFF && m_xen) begin
          ps = {1'b0, mb_pg} + 9'd1;
          mb_pg = ps[7:0];
          if (ps[8]) mb_hi = mb_hi + 8'd1;
          if (mw_pg[7:1] == 7'h7F) mw_hi = mw_hi + 8'd1;
          mw_pg[7:1] = mw_pg[7:1] + 7'd1;
        end
        m_addr = m_addr + 16'd1;
        m_cnt  = m_cnt - 16'd1;
        if (e.tc) m_act = 1'b0;
      end
    end
    e.act = m_act;
    e.ab  = {mb_hi, mb_pg, m_addr};
    e.aw  = {mw_hi, mw_pg[7:1], m_addr, 1'b0};
    e.rb  = {1'b0, m_cnt + 16'd1};
    e.rw  = {m_cnt + 16'd1, 1'b0};
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic setup(input logic [15:0] a, input logic [15:0] c, input logic [7:0] p,
                       input logic [7:0] h, input bit x, input bit au);
    @(negedge clk);
    base_addr_i = a; base_cnt_i = c; page_i = p; hipage_i = h;
    cross_en_i = x; autoinit_i = au;
  endtask

  // monitor: combinational pulse before the edge, state after it
  initial begin
    exp_t  e;
    string t;
    forever begin
      @(negedge clk);
      #4;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "tc byte", {31'd0, tc_b}, {31'd0, e.tc});
        chk(t, "tc word", {31'd0, tc_w}, {31'd0, e.tc});
        @(posedge clk);
        #2;
        chk(t, "active", {30'd0, act_b, act_w}, {30'd0, e.act, e.act});
        chk(t, "bus byte", bus_b, e.ab);
        chk(t, "bus word", bus_w, e.aw);
        chk(t, "residue byte", {15'd0, res_b}, {15'd0, e.rb});
        chk(t, "residue word", {15'd0, res_w}, {15'd0, e.rw});
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_addr = '0; m_cnt = 16'hFFFF; mb_pg = '0; mb_hi = '0; mw_pg = '0; mw_hi = '0;
    b_addr = '0; b_cnt = '0; b_pg = '0; b_hi = '0;
    m_act = 1'b0; m_auto = 1'b0; m_xen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state, then R9 step while idle is ignored
    cyc("R1", 1'b0, 1'b0);
    cyc("R9", 1'b0, 1'b1);
    // R2 R3 R4 mapping; R7 three steps for count 2; R8 residue
    setup(16'h1234, 16'd2, 8'h35, 8'hA7, 1'b0, 1'b0);
    cyc("R2 R3 R4", 1'b1, 1'b0);
    cyc("R8", 1'b0, 1'b1);
    cyc("R7", 1'b0, 1'b1);
    cyc("R7", 1'b0, 1'b1);
    cyc("R9", 1'b0, 1'b1);
    cyc("R9", 1'b0, 1'b1);
    cyc("R8", 1'b0, 1'b0);
    // R5 wrap inside the page
    setup(16'hFFFE, 16'd4, 8'h13, 8'h00, 1'b0, 1'b0);
    cyc("R5", 1'b1, 1'b0);
    cyc("R5", 1'b0, 1'b1);
    cyc("R5", 1'b0, 1'b1);
    cyc("R5", 1'b0, 1'b1);
    // R6 carry through page into high page
    setup(16'hFFFF, 16'd3, 8'hFF, 8'h01, 1'b1, 1'b0);
    cyc("R6", 1'b1, 1'b0);
    cyc("R6", 1'b0, 1'b1);
    cyc("R6", 1'b0, 1'b1);
    setup(16'hFFFF, 16'd3, 8'h3E, 8'h05, 1'b1, 1'b0);
    cyc("R6", 1'b1, 1'b0);
    cyc("R6", 1'b0, 1'b1);
    // R10 auto-initialize reloads at terminal count
    setup(16'h0100, 16'd1, 8'h02, 8'h00, 1'b0, 1'b1);
    cyc("R10", 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) cyc("R10", 1'b0, 1'b1);
    // R11 load coincides with a terminal-count step
    setup(16'h0ABC, 16'd7, 8'h41, 8'h10, 1'b0, 1'b0);
    cyc("R11", 1'b1, 1'b1);
    cyc("R3", 1'b0, 1'b1);
    cyc("R3", 1'b0, 1'b0);
    @(negedge clk);
    load_i = 1'b0;
    step_i = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule